// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block is the receive side of a serial peripheral command port. A host clocks 16-bit frames into it, most significant bit first, with the chip select held low. Each frame carries four fields: a watchdog toggle bit, a 2-bit channel selector, a 3-bit register address and a 9-bit payload. When chip select returns high, the last complete frame is decoded. Its payload goes either into one of several per-channel register banks or into a register shared by all four channels.

The serial lines are oversampled in the system clock domain. The serial clock, chip select and data each pass through a synchronizer. Data is taken on each synchronized rising edge of the serial clock while select is low. Several frames may follow one another inside one select period, so the device can sit in a daisy chain. Only the bits shifted in last are kept. A transfer whose length is not a whole number of frames is thrown away. The block also reports a watchdog refresh each time the toggle bit of an accepted frame differs from that of the frame accepted before it.

Top module: `cmd_frame_decoder`

## Requirements
- R1: A frame is 16 bits sent MSB first. Bit 15 is the watchdog bit, bits 14:13 the channel selector, bits 12:10 the address, bit 9 spare, and bits 8:0 the payload.
- R2: Addresses 001 (drive), 010 (setup A), 011 (setup B) and 100 (current limit) write the payload only into channel k = selector. Channel k sits in bits [9k+8:9k] of the matching output. All other channels keep their values.
- R3: Address 000 writes the payload into the status-select register, whatever the selector holds.
- R4: Address 101 (global) and address 111 (calibration) are written only when the selector is 00. With any other selector the frame changes no register.
- R5: A frame with address 110 changes no register.
- R6: A transfer of zero bits, or of any bit count that is not a multiple of 16, changes no register and gives no watchdog pulse.
- R7: When a transfer holds several whole frames, only the last 16 bits shifted in are decoded.
- R8: An accepted frame (length valid, any address) raises `wd_pulse_o` for exactly one cycle if its bit 15 differs from the bit 15 of the previously accepted frame. The reference bit is 0 after reset.
- R9: Reset clears every register output to zero and holds `wd_pulse_o` low.
- R10: The spare bit 9 has no effect on decoding.
- R11: Register outputs change only after chip select rises. They stay unchanged while bits are still being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| pwm_o | output | 36 | Drive register, 9 bits per channel |
| cfg0_o | output | 36 | Setup A register, 9 bits per channel |
| cfg1_o | output | 36 | Setup B register, 9 bits per channel |
| ocur_o | output | 36 | Current-limit register, 9 bits per channel |
| stat_sel_o | output | 9 | Status-select register |
| glob_o | output | 9 | Global register |
| cal_o | output | 9 | Calibration register |
| wd_pulse_o | output | 1 | One-cycle watchdog refresh pulse |

## Verification
Single directed frames to each address, with every selector value, show that each write reaches only its own channel slice and register. They also show that the global and calibration registers reject a nonzero selector. Transfers of 0, 15, 17 and 48 bits separate length rejection from last-frame selection. A frame held open before chip select rises shows that no register changes early. A long run of random frames, mixing random lengths, addresses, selectors and toggle bits, is compared against a reference model of the register bank and of the watchdog reference bit.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 9;
  localparam int SEL_W   = 2;
  localparam int NUM_CH  = 1 << SEL_W;

  typedef enum logic [2:0] {
    A_STAT = 3'b000,
    A_PWM  = 3'b001,
    A_CFG0 = 3'b010,
    A_CFG1 = 3'b011,
    A_OCUR = 3'b100,
    A_GLOB = 3'b101,
    A_RSVD = 3'b110,
    A_CAL  = 3'b111
  } reg_addr_e;

  typedef struct packed {
    logic              wd;
    logic [SEL_W-1:0]  sel;
    reg_addr_e         addr;
    logic              spare;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign q    = chain_q[STAGES-1];
  assign rise = chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import cmd_dec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_rise,
  input  logic   cs_low,
  input  logic   cs_fall,
  input  logic   cs_rise,
  input  logic   sdi,
  output logic   frame_vld,
  output frame_t frame
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               any_q, any_d;
  logic               shift_en;

  assign shift_en = sclk_rise && cs_low && !cs_fall;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    any_d = any_q;
    if (cs_fall) begin
      cnt_d = '0;
      any_d = 1'b0;
    end else if (shift_en) begin
      sh_d  = {sh_q[FRAME_W-2:0], sdi};
      cnt_d = cnt_q + CNT_W'(1);
      any_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      any_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      any_q <= any_d;
    end
  end

  assign frame_vld = cs_rise && any_q && (cnt_q == '0);
  assign frame     = frame_t'(sh_q);

  // R1: the 16th bit of a frame wraps the counter back to frame alignment
  assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == '0 && any_q));

  // R6: a fresh select period starts with nothing counted
  assert_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (!any_q && cnt_q == '0));
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import cmd_dec_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  frame_t                   frame,
  output logic [NUM_CH*DATA_W-1:0] pwm_o,
  output logic [NUM_CH*DATA_W-1:0] cfg0_o,
  output logic [NUM_CH*DATA_W-1:0] cfg1_o,
  output logic [NUM_CH*DATA_W-1:0] ocur_o,
  output logic [DATA_W-1:0]        stat_sel_o,
  output logic [DATA_W-1:0]        glob_o,
  output logic [DATA_W-1:0]        cal_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DATA_W-1:0] pwm_q, pwm_d, cfg0_q, cfg0_d, cfg1_q, cfg1_d, ocur_q, ocur_d;
    logic              hit;

    assign hit = wr_en && (frame.sel == SEL_W'(g));

    always_comb begin
      pwm_d  = (hit && frame.addr == A_PWM)  ? frame.data : pwm_q;
      cfg0_d = (hit && frame.addr == A_CFG0) ? frame.data : cfg0_q;
      cfg1_d = (hit && frame.addr == A_CFG1) ? frame.data : cfg1_q;
      ocur_d = (hit && frame.addr == A_OCUR) ? frame.data : ocur_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pwm_q  <= '0;
        cfg0_q <= '0;
        cfg1_q <= '0;
        ocur_q <= '0;
      end else begin
        pwm_q  <= pwm_d;
        cfg0_q <= cfg0_d;
        cfg1_q <= cfg1_d;
        ocur_q <= ocur_d;
      end
    end

    assign pwm_o [g*DATA_W +: DATA_W] = pwm_q;
    assign cfg0_o[g*DATA_W +: DATA_W] = cfg0_q;
    assign cfg1_o[g*DATA_W +: DATA_W] = cfg1_q;
    assign ocur_o[g*DATA_W +: DATA_W] = ocur_q;
  end

  logic [DATA_W-1:0] stat_q, stat_d, glob_q, glob_d, cal_q, cal_d;
  logic              shared_ok;

  assign shared_ok = wr_en && (frame.sel == '0);

  always_comb begin
    stat_d = (wr_en && frame.addr == A_STAT)     ? frame.data : stat_q;
    glob_d = (shared_ok && frame.addr == A_GLOB) ? frame.data : glob_q;
    cal_d  = (shared_ok && frame.addr == A_CAL)  ? frame.data : cal_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      glob_q <= '0;
      cal_q  <= '0;
    end else begin
      stat_q <= stat_d;
      glob_q <= glob_d;
      cal_q  <= cal_d;
    end
  end

  assign stat_sel_o = stat_q;
  assign glob_o     = glob_q;
  assign cal_o      = cal_q;

  // R11: no accepted frame, no register movement
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pwm_o) && $stable(cfg0_o) && $stable(cfg1_o) &&
                $stable(ocur_o) && $stable(stat_sel_o) && $stable(glob_o) && $stable(cal_o)));

  // R5: the unassigned address leaves the bank untouched
  assert_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && frame.addr == A_RSVD) |=> ($stable(pwm_o) && $stable(cfg0_o) && $stable(cfg1_o) &&
                $stable(ocur_o) && $stable(stat_sel_o) && $stable(glob_o) && $stable(cal_o)));

  // R4: shared registers refuse a nonzero selector
  assert_shared_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && frame.sel != '0) |=> ($stable(glob_o) && $stable(cal_o)));
endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder
  import cmd_dec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk,
  input  logic                     cs_n,
  input  logic                     sdi,
  output logic [NUM_CH*DATA_W-1:0] pwm_o,
  output logic [NUM_CH*DATA_W-1:0] cfg0_o,
  output logic [NUM_CH*DATA_W-1:0] cfg1_o,
  output logic [NUM_CH*DATA_W-1:0] ocur_o,
  output logic [DATA_W-1:0]        stat_sel_o,
  output logic [DATA_W-1:0]        glob_o,
  output logic [DATA_W-1:0]        cal_o,
  output logic                     wd_pulse_o
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic sclk_q, sclk_rise, sclk_fall;
  logic cs_q, cs_rise, cs_fall;
  logic sdi_q, sdi_rise, sdi_fall;

  edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk (
    .clk(clk), .rst_n(rst_i_n), .d(sclk), .q(sclk_q), .rise(sclk_rise), .fall(sclk_fall));
  edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs (
    .clk(clk), .rst_n(rst_i_n), .d(cs_n), .q(cs_q), .rise(cs_rise), .fall(cs_fall));
  edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi (
    .clk(clk), .rst_n(rst_i_n), .d(sdi), .q(sdi_q), .rise(sdi_rise), .fall(sdi_fall));

  logic   frame_vld;
  frame_t frame;

  frame_shifter u_shift (
    .clk(clk), .rst_n(rst_i_n), .sclk_rise(sclk_rise), .cs_low(!cs_q),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sdi(sdi_q),
    .frame_vld(frame_vld), .frame(frame));

  reg_bank u_bank (
    .clk(clk), .rst_n(rst_i_n), .wr_en(frame_vld), .frame(frame),
    .pwm_o(pwm_o), .cfg0_o(cfg0_o), .cfg1_o(cfg1_o), .ocur_o(ocur_o),
    .stat_sel_o(stat_sel_o), .glob_o(glob_o), .cal_o(cal_o));

  logic wd_prev_q, wd_prev_d, wd_pulse_q, wd_pulse_d;

  always_comb begin
    wd_pulse_d = frame_vld && (frame.wd != wd_prev_q);
    wd_prev_d  = frame_vld ? frame.wd : wd_prev_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      wd_prev_q  <= 1'b0;
      wd_pulse_q <= 1'b0;
    end else begin
      wd_prev_q  <= wd_prev_d;
      wd_pulse_q <= wd_pulse_d;
    end
  end

  assign wd_pulse_o = wd_pulse_q;

  // R8: the refresh pulse lasts a single cycle
  assert_wd_single_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    wd_pulse_o |=> !wd_pulse_o);

  // R8: a refresh pulse is always caused by an accepted frame
  assert_wd_source_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    wd_pulse_o |-> $past(frame_vld));

  // R9: while reset is applied nothing is reported
  assert_rst_quiet_R9: assert property (@(posedge clk)
    !rst_i_n |-> (!wd_pulse_o && glob_o == '0 && cal_o == '0));
endmodule

// File: tb/cmd_frame_decoder_test.sv
module cmd_frame_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic [35:0] pwm_o, cfg0_o, cfg1_o, ocur_o;
  logic [8:0]  stat_sel_o, glob_o, cal_o;
  logic        wd_pulse_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_frame_decoder uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .pwm_o(pwm_o), .cfg0_o(cfg0_o), .cfg1_o(cfg1_o), .ocur_o(ocur_o),
    .stat_sel_o(stat_sel_o), .glob_o(glob_o), .cal_o(cal_o), .wd_pulse_o(wd_pulse_o));

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 1'b0;

  logic [35:0] e_pwm, e_cfg0, e_cfg1, e_ocur;
  logic [8:0]  e_stat, e_glob, e_cal;
  logic        e_wd;

  always @(posedge clk) if (rst_n && wd_pulse_o) pulses++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    e_pwm = '0; e_cfg0 = '0; e_cfg1 = '0; e_ocur = '0;
    e_stat = '0; e_glob = '0; e_cal = '0; e_wd = 1'b0;
  endtask

  function automatic int model_apply(input int n, input logic [63:0] bits);
    logic [15:0] f;
    int p;
    p = 0;
    if (n > 0 && n % 16 == 0) begin
      f = bits[15:0];
      if (f[15] != e_wd) p = 1;
      e_wd = f[15];
      case (f[12:10])
        3'b000: e_stat = f[8:0];
        3'b001: e_pwm [f[14:13]*9 +: 9] = f[8:0];
        3'b010: e_cfg0[f[14:13]*9 +: 9] = f[8:0];
        3'b011: e_cfg1[f[14:13]*9 +: 9] = f[8:0];
        3'b100: e_ocur[f[14:13]*9 +: 9] = f[8:0];
        3'b101: if (f[14:13] == 2'b00) e_glob = f[8:0];
        3'b111: if (f[14:13] == 2'b00) e_cal = f[8:0];
        default: ;
      endcase
    end
    return p;
  endfunction

  task automatic compare_state(input string req);
    check({req, " drive"},  64'(pwm_o),      64'(e_pwm));
    check({req, " setupA"}, 64'(cfg0_o),     64'(e_cfg0));
    check({req, " setupB"}, 64'(cfg1_o),     64'(e_cfg1));
    check({req, " ilim"},   64'(ocur_o),     64'(e_ocur));
    check({req, " stat"},   64'(stat_sel_o), 64'(e_stat));
    check({req, " glob"},   64'(glob_o),     64'(e_glob));
    check({req, " cal"},    64'(cal_o),      64'(e_cal));
  endtask

  task automatic shift_bits(input int n, input logic [63:0] bits);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
  endtask

  task automatic run(input string req, input int n, input logic [63:0] bits);
    int p0, ep;
    p0 = pulses;
    shift_bits(n, bits);
    cs_n = 1'b1;
    tick(10);
    ep = model_apply(n, bits);
    compare_state(req);
    check({req, " wd pulses"}, 64'(pulses - p0), 64'(ep));
  endtask

  function automatic logic [15:0] mk(input logic wd, input logic [1:0] sel,
                                     input logic [2:0] a, input logic sp, input logic [8:0] d);
    return {wd, sel, a, sp, d};
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    model_reset();
    tick(5);
    // R9: outputs cleared while in reset
    compare_state("R9 reset");
    check("R9 pulse low", 64'(wd_pulse_o), 64'(0));
    rst_n = 1'b1;
    tick(5);

    // R1 R2 R8: drive register, channel 2, watchdog bit set -> pulse
    run("R2 drive ch2", 16, 64'(mk(1'b1, 2'b10, 3'b001, 1'b0, 9'h1A5)));
    // R2: every channel of every per-channel register
    for (int c = 0; c < 4; c++) begin
      run("R2 setupA", 16, 64'(mk(1'b1, 2'(c), 3'b010, 1'b0, 9'(9'h050 + c))));
      run("R2 setupB", 16, 64'(mk(1'b0, 2'(c), 3'b011, 1'b0, 9'(9'h120 + c))));
      run("R2 ilim",   16, 64'(mk(1'b1, 2'(c), 3'b100, 1'b0, 9'(9'h0F0 + c))));
    end
    // R3: status select ignores selector
    run("R3 stat sel3", 16, 64'(mk(1'b0, 2'b11, 3'b000, 1'b0, 9'h0AA)));
    // R4: shared registers need selector 00
    run("R4 glob sel1 ignored", 16, 64'(mk(1'b1, 2'b01, 3'b101, 1'b0, 9'h1FF)));
    run("R4 glob sel0",         16, 64'(mk(1'b0, 2'b00, 3'b101, 1'b0, 9'h133)));
    run("R4 cal sel2 ignored",  16, 64'(mk(1'b1, 2'b10, 3'b111, 1'b0, 9'h1C3)));
    run("R4 cal sel0",          16, 64'(mk(1'b1, 2'b00, 3'b111, 1'b0, 9'h063)));
    // R5 R8: reserved address changes nothing but still toggles watchdog
    run("R5 rsvd", 16, 64'(mk(1'b0, 2'b00, 3'b110, 1'b0, 9'h1EE)));
    // R10: spare bit set
    run("R10 spare", 16, 64'(mk(1'b1, 2'b01, 3'b001, 1'b1, 9'h0C7)));
    // R6: bad lengths
    run("R6 zero bits", 0, 64'(0));
    run("R6 15 bits", 15, 64'(mk(1'b0, 2'b00, 3'b101, 1'b0, 9'h001)));
    run("R6 17 bits", 17, {47'(0), mk(1'b0, 2'b00, 3'b101, 1'b0, 9'h002), 1'b0});
    // R7: three frames, only the last counts
    run("R7 daisy", 48, {16'(0), mk(1'b0, 2'b11, 3'b001, 1'b0, 9'h111),
                         mk(1'b0, 2'b11, 3'b010, 1'b0, 9'h122),
                         mk(1'b0, 2'b11, 3'b100, 1'b0, 9'h144)});
    // R11: full frame shifted, select still low -> unchanged
    begin
      logic [15:0] f;
      int p0, ep;
      f = mk(1'b1, 2'b00, 3'b101, 1'b0, 9'h0BE);
      p0 = pulses;
      shift_bits(16, 64'(f));
      tick(10);
      compare_state("R11 select low");
      cs_n = 1'b1;
      tick(10);
      ep = model_apply(16, 64'(f));
      compare_state("R11 after rise");
      check("R11 wd pulses", 64'(pulses - p0), 64'(ep));
    end

    // random traffic
    for (int k = 0; k < 220; k++) begin
      int r, n;
      logic [63:0] b;
      r = int'($urandom % 10);
      b = {$urandom, $urandom};
      if (r < 6)       n = 16;
      else if (r == 6) n = 32;
      else if (r == 7) n = 48;
      else if (r == 8) begin
        n = 1 + int'($urandom % 47);
        if (n % 16 == 0) n++;
      end else n = 0;
      run("R1 R2 R7 random", n, b);
    end

    // R9: reset after traffic
    rst_n = 1'b0;
    tick(3);
    model_reset();
    compare_state("R9 re-reset");
    rst_n = 1'b1;
    tick(5);
    run("R8 after reset wd0", 16, 64'(mk(1'b0, 2'b00, 3'b000, 1'b0, 9'h005)));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule